// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes a byte-wide one-time-programmable or UV-erasable EPROM. It works on one address at a time and uses a closed pulse-and-verify loop. A host raises `start` to open a session. It then hands over address/data pairs on a valid/ready handshake and marks the final pair with `req_last`. For the whole session the sequencer holds the programming-supply enable and the margin-verify enable high.

For each byte it first reads the cell. A cell that already holds the target is skipped. A cell with a 0 where the target wants a 1 cannot be programmed, because programming only clears bits, so that byte is reported and left untouched. Any other byte gets a series of fixed-length program pulses with the data bus driven and output-enable held inactive. A verify read follows each pulse, and the loop moves on at the first matching readback with no extra pulse.

Every byte ends with a one-cycle status report that carries its pulse count. If a byte uses up its pulse budget without matching, the session stops and a sticky error records the failing address. Pulse length comes from the clock frequency, so the same code serves any clock.

Top module: `eprom_prog_seq`

## Requirements
- R1: Each program pulse holds `mem_ce_n` low for exactly (CLK_HZ*PULSE_US)/1e6 cycles. During the pulse `mem_oe_n` stays high and the current target byte is driven on `mem_dq`.
- R2: After every program pulse the byte is read back with `mem_ce_n` and `mem_oe_n` both low. Pulses repeat until the readback equals the target, and the byte is then reported with status 0 (programmed).
- R3: No pulse is applied after the first matching verify. The reported `byte_pulses` equals the number of pulses the memory actually received for that byte.
- R4: `vpp_en` and `margin_en` are high from the cycle after `start` is taken in idle until the session ends or aborts, and low otherwise. Chip-enable strobes occur only while both are high.
- R5: A target with any bit at 1 where the first read returns 0 is reported with status 2 (unreachable) and 0 pulses. The memory cell is left unchanged, and the session continues with the next byte.
- R6: A byte whose first read already equals its target, such as 0xFF over an erased cell, is reported with status 1 (skipped) and 0 pulses.
- R7: If MAX_PULSES pulses pass without a match, the byte is reported with status 3 (budget exceeded) and `byte_pulses` = MAX_PULSES. In the same cycle `err` rises and holds, `err_addr` holds the byte's address, `done` pulses, and the session ends.
- R8: The sequencer never drives `mem_dq` while `mem_oe_n` is low. Address and bus settle for GUARD_CYC cycles before each read strobe and before each program pulse.
- R9: `req_ready` is high only while a session waits for the next pair. For the pair flagged `req_last`, the `done` pulse comes in the same cycle as that byte's status report, and the session then closes.
- R10: After reset and in idle, `busy`, `vpp_en`, `margin_en`, `req_ready` and `err` are low, and `mem_ce_n` and `mem_oe_n` are high. A new `start` clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a session when idle |
| req_valid | input | 1 | Address/data pair offered |
| req_ready | output | 1 | Sequencer takes the pair this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | DATA_W | Target data |
| req_last | input | 1 | Pair is the final one of the session |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | DATA_W | Memory data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| vpp_en | output | 1 | Programming supply enable |
| margin_en | output | 1 | Margin-verify condition enable |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle pulse at session end or abort |
| err | output | 1 | Sticky pulse-budget error |
| err_addr | output | ADDR_W | Address that exhausted its budget |
| byte_valid | output | 1 | One-cycle per-byte status report |
| byte_status | output | 2 | 0 programmed, 1 skipped, 2 unreachable, 3 budget exceeded |
| byte_pulses | output | $clog2(MAX_PULSES+1) | Pulses applied to the reported byte |

## Verification
Two events can land in the same cycle: a byte's status report and the end of the session. This happens either on the last pair of a session or when a byte runs out its pulse budget. The bench sets up both cases. In a directed session the final byte needs exactly the budget, and a second session holds a byte that needs one pulse more than the budget allows. At each status report the bench checks that `done`, `err` and `err_addr` appear at the same falling-edge sample as `byte_valid`. It then checks that the supply enables are low one cycle later and that no further pair is accepted.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WAIT,
      S_RD_SET,
      S_RD_OE,
      S_EVAL,
      S_PG_SET,
      S_PG_PULSE,
      S_PG_HOLD
   } seq_st_t;

   typedef enum logic [1:0] {
      BS_OK      = 2'd0,
      BS_SKIP    = 2'd1,
      BS_UNREACH = 2'd2,
      BS_BUDGET  = 2'd3
   } byte_stat_t;

endpackage

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (ld)
         cnt <= ld_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/eprom_seq_cmp.sv
module eprom_seq_cmp #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] rd,
   input  logic [DATA_W-1:0] tgt,
   output logic              match,
   output logic              unreach
);

   logic [DATA_W-1:0] bad;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign bad[i] = tgt[i] & ~rd[i];
   end

   assign match   = (rd == tgt);
   assign unreach = |bad;

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
   import eprom_seq_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter int CLK_HZ     = 250_000_000,
   parameter int PULSE_US   = 100,
   parameter int MAX_PULSES = 25,
   parameter int GUARD_CYC  = 4,
   localparam int PW        = $clog2(MAX_PULSES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_last,
   output logic [ADDR_W-1:0] mem_addr,
   inout  wire  [DATA_W-1:0] mem_dq,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              vpp_en,
   output logic              margin_en,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] err_addr,
   output logic              byte_valid,
   output logic [1:0]        byte_status,
   output logic [PW-1:0]     byte_pulses
);

   localparam longint unsigned PULSE_L = (longint'(CLK_HZ) * longint'(PULSE_US)) / 64'd1000000;
   localparam int PULSE_CYC = int'(PULSE_L);
   localparam int TMAX      = (PULSE_CYC > GUARD_CYC) ? PULSE_CYC : GUARD_CYC;
   localparam int TW        = $clog2(TMAX + 1);

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("pulse length rounds to zero cycles");
   end
   if (GUARD_CYC < 1) begin : g_bad_guard
      $error("GUARD_CYC must be at least 1");
   end
   if (MAX_PULSES < 1) begin : g_bad_max
      $error("MAX_PULSES must be at least 1");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("bus widths must be positive");
   end

   localparam logic [TW-1:0] T_GUARD = TW'(GUARD_CYC - 1);
   localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);

   seq_st_t           st, st_n;
   logic              t_ld, t_zero;
   logic [TW-1:0]     t_val;
   logic [ADDR_W-1:0] a_q;
   logic [DATA_W-1:0] d_q, rd_q;
   logic              last_q;
   logic [PW-1:0]     pcnt;
   logic              cmp_match, cmp_unreach;
   logic              dq_oe;
   logic              first_rd;

   eprom_seq_timer #(.W(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (t_ld),
      .ld_val (t_val),
      .zero   (t_zero)
   );

   eprom_seq_cmp #(.DATA_W(DATA_W)) u_cmp (
      .rd      (rd_q),
      .tgt     (d_q),
      .match   (cmp_match),
      .unreach (cmp_unreach)
   );

   assign first_rd = (pcnt == '0);

   always_comb begin
      st_n  = st;
      t_ld  = 1'b0;
      t_val = T_GUARD;
      case (st)
         S_IDLE:     if (start) st_n = S_WAIT;
         S_WAIT:     if (req_valid) begin
                        st_n = S_RD_SET; t_ld = 1'b1;
                     end
         S_RD_SET:   if (t_zero) begin
                        st_n = S_RD_OE; t_ld = 1'b1;
                     end
         S_RD_OE:    if (t_zero) st_n = S_EVAL;
         S_EVAL: begin
            if ((first_rd && cmp_unreach) || cmp_match)
               st_n = last_q ? S_IDLE : S_WAIT;
            else if (pcnt == PW'(MAX_PULSES))
               st_n = S_IDLE;
            else begin
               st_n = S_PG_SET; t_ld = 1'b1;
            end
         end
         S_PG_SET:   if (t_zero) begin
                        st_n = S_PG_PULSE; t_ld = 1'b1; t_val = T_PULSE;
                     end
         S_PG_PULSE: if (t_zero) begin
                        st_n = S_PG_HOLD; t_ld = 1'b1;
                     end
         S_PG_HOLD:  if (t_zero) begin
                        st_n = S_RD_SET; t_ld = 1'b1;
                     end
         default:    st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         a_q         <= '0;
         d_q         <= '1;
         rd_q        <= '1;
         last_q      <= 1'b0;
         pcnt        <= '0;
         done        <= 1'b0;
         err         <= 1'b0;
         err_addr    <= '0;
         byte_valid  <= 1'b0;
         byte_status <= BS_OK;
         byte_pulses <= '0;
      end else begin
         st         <= st_n;
         done       <= 1'b0;
         byte_valid <= 1'b0;
         case (st)
            S_IDLE: if (start) err <= 1'b0;
            S_WAIT: if (req_valid) begin
               a_q    <= req_addr;
               d_q    <= req_data;
               last_q <= req_last;
               pcnt   <= '0;
            end
            S_RD_OE:  if (t_zero) rd_q <= mem_dq;
            S_PG_SET: if (t_zero) pcnt <= pcnt + 1'b1;
            S_EVAL: begin
               byte_pulses <= pcnt;
               if (first_rd && cmp_unreach) begin
                  byte_valid  <= 1'b1;
                  byte_status <= BS_UNREACH;
                  done        <= last_q;
               end else if (cmp_match) begin
                  byte_valid  <= 1'b1;
                  byte_status <= first_rd ? BS_SKIP : BS_OK;
                  done        <= last_q;
               end else if (pcnt == PW'(MAX_PULSES)) begin
                  byte_valid  <= 1'b1;
                  byte_status <= BS_BUDGET;
                  done        <= 1'b1;
                  err         <= 1'b1;
                  err_addr    <= a_q;
               end
            end
            default: ;
         endcase
      end
   end

   assign busy      = (st != S_IDLE);
   assign vpp_en    = busy;
   assign margin_en = busy;
   assign req_ready = (st == S_WAIT);
   assign mem_addr  = a_q;
   assign mem_oe_n  = (st != S_RD_OE);
   assign mem_ce_n  = !((st == S_RD_OE) || (st == S_PG_PULSE));
   assign dq_oe     = (st == S_PG_SET) || (st == S_PG_PULSE) || (st == S_PG_HOLD);
   assign mem_dq    = dq_oe ? d_q : 'z;

endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
   parameter int MAX_PULSES = 25,
   parameter int PULSE_CYC  = 10,
   parameter int PW         = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_ce_n,
   input logic          mem_oe_n,
   input logic          dq_oe,
   input logic          vpp_en,
   input logic          margin_en,
   input logic          req_ready,
   input logic          busy,
   input logic          done,
   input logic          byte_valid,
   input logic [1:0]    byte_status,
   input logic [PW-1:0] byte_pulses
);

   int run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run <= 0;
      else if (!mem_ce_n && mem_oe_n)
         run <= run + 1;
      else
         run <= 0;
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce_n && run > 0) |-> run == PULSE_CYC);                          // R1
   AST_PULSE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && mem_oe_n) |-> dq_oe);                                   // R1
   AST_STROBE_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> (vpp_en && margin_en));                                 // R4
   AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !dq_oe);                                                // R8
   AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> byte_pulses <= PW'(MAX_PULSES));                       // R7
   AST_NO_PULSE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && (byte_status == 2'd1 || byte_status == 2'd2)) |-> byte_pulses == '0); // R5
   AST_DONE_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!vpp_en && !busy));                                         // R9
   AST_READY_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (busy && mem_ce_n));                                    // R9

endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
   .MAX_PULSES (MAX_PULSES),
   .PULSE_CYC  (PULSE_CYC),
   .PW         (PW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_ce_n    (mem_ce_n),
   .mem_oe_n    (mem_oe_n),
   .dq_oe       (dq_oe),
   .vpp_en      (vpp_en),
   .margin_en   (margin_en),
   .req_ready   (req_ready),
   .busy        (busy),
   .done        (done),
   .byte_valid  (byte_valid),
   .byte_status (byte_status),
   .byte_pulses (byte_pulses)
);

// File: tb/eprom_prog_seq_bench.sv
module eprom_prog_seq_bench;

   localparam int AW     = 6;
   localparam int DW     = 8;
   localparam int CLKHZ  = 100_000;
   localparam int PUS    = 100;
   localparam int MAXP   = 5;
   localparam int GUARD  = 2;
   localparam int PCYC   = 10;
   localparam int PW     = $clog2(MAXP + 1);
   localparam int NWORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_last = 1'b0;
   logic [AW-1:0] mem_addr;
   wire  [DW-1:0] mem_dq;
   logic          mem_ce_n, mem_oe_n, vpp_en, margin_en, busy, done, err;
   logic [AW-1:0] err_addr;
   logic          byte_valid;
   logic [1:0]    byte_status;
   logic [PW-1:0] byte_pulses;

   int checks = 0;
   int failures = 0;
   bit wd_hit = 1'b0;

   always #2 clk = ~clk;

   eprom_prog_seq #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_HZ(CLKHZ), .PULSE_US(PUS),
      .MAX_PULSES(MAXP), .GUARD_CYC(GUARD)
   ) u_eprom_prog_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
      .req_last(req_last), .mem_addr(mem_addr), .mem_dq(mem_dq),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .vpp_en(vpp_en),
      .margin_en(margin_en), .busy(busy), .done(done), .err(err),
      .err_addr(err_addr), .byte_valid(byte_valid), .byte_status(byte_status),
      .byte_pulses(byte_pulses)
   );

   // behavioural memory: pulses only clear bits, each cell needs a set count
   logic [DW-1:0] mem   [NWORDS];
   int            need  [NWORDS];
   int            hits  [NWORDS];
   int            run = 0;
   logic [DW-1:0] pg_data;
   logic [DW-1:0] cur_tgt = '0;

   assign mem_dq = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr] : 'z;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!mem_ce_n && mem_oe_n) begin
         run     <= run + 1;
         pg_data <= mem_dq;
      end else if (run > 0) begin
         chk(run == PCYC, "R1 pulse width", run, PCYC);
         chk(pg_data == cur_tgt, "R1 pulse data", int'(pg_data), int'(cur_tgt));
         if (vpp_en && margin_en) begin
            hits[mem_addr] <= hits[mem_addr] + 1;
            if (hits[mem_addr] + 1 >= need[mem_addr])
               mem[mem_addr] <= mem[mem_addr] & pg_data;
         end
         run <= 0;
      end
   end

   function automatic int exp_stat(input logic [DW-1:0] o, input logic [DW-1:0] t, input int n);
      if ((t & ~o) != '0) return 2;
      if (o == t)         return 1;
      if (n <= MAXP)      return 0;
      return 3;
   endfunction

   function automatic int exp_pulses(input logic [DW-1:0] o, input logic [DW-1:0] t, input int n);
      int s = exp_stat(o, t, n);
      if (s == 0) return n;
      if (s == 3) return MAXP;
      return 0;
   endfunction

   task automatic open_session();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && vpp_en && margin_en && !err, "R4 R10 session open", int'(vpp_en), 1);
   endtask

   // returns 1 when the session ended (last byte or abort)
   task automatic send_byte(input int a, input logic [DW-1:0] o, input logic [DW-1:0] t,
                            input int n, input bit last, output bit ended);
      int es, ep;
      mem[a]  = o;
      need[a] = n;
      hits[a] = 0;
      cur_tgt = t;
      es = exp_stat(o, t, n);
      ep = exp_pulses(o, t, n);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = AW'(a);
      req_data  = t;
      req_last  = last;
      @(negedge clk);
      req_valid = 1'b0;
      while (!byte_valid) @(negedge clk);
      chk(int'(byte_status) == es, "R2 R5 R6 R7 status", int'(byte_status), es);
      chk(int'(byte_pulses) == ep, "R3 pulse count", int'(byte_pulses), ep);
      chk(hits[a] == ep, "R3 pulses seen by memory", hits[a], ep);
      if (es == 0)
         chk(mem[a] == t, "R2 verified content", int'(mem[a]), int'(t));
      if (es == 2 || es == 1)
         chk(mem[a] == o, "R5 R6 cell untouched", int'(mem[a]), int'(o));
      ended = last || (es == 3);
      chk(done == ended, "R9 done with last status", int'(done), int'(ended));
      if (es == 3) begin
         chk(err == 1'b1, "R7 err raised", int'(err), 1);
         chk(int'(err_addr) == a, "R7 err_addr", int'(err_addr), a);
      end
      if (ended) begin
         @(negedge clk);
         chk(!vpp_en && !margin_en && !busy && !req_ready, "R4 R9 session closed",
             int'(vpp_en), 0);
      end else begin
         chk(vpp_en && margin_en, "R4 supply held", int'(vpp_en), 1);
      end
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      wd_hit = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit ended;
      void'($urandom(32'd20417));
      for (int i = 0; i < NWORDS; i++) begin
         mem[i] = '1; need[i] = 1; hits[i] = 0;
      end
      repeat (3) @(negedge clk);
      chk(!busy && !vpp_en && !margin_en && !req_ready && !err && mem_ce_n && mem_oe_n,
          "R10 reset state", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !req_ready, "R10 idle after reset", int'(busy), 0);

      // directed session
      open_session();
      send_byte(0, 8'hFF, 8'hFF, 1, 1'b0, ended);          // R6
      send_byte(1, 8'hFF, 8'h5A, 1, 1'b0, ended);          // R2 single pulse
      send_byte(2, 8'hFF, 8'h00, 3, 1'b0, ended);          // R2 R3 repeated
      send_byte(3, 8'h0F, 8'h1F, 2, 1'b0, ended);          // R5 unreachable
      send_byte(4, 8'hA5, 8'hA5, 1, 1'b0, ended);          // R6 already set
      send_byte(5, 8'hFF, 8'h3C, MAXP, 1'b1, ended);       // R7 boundary: exactly budget, R9
      chk(err == 1'b0, "R7 no error at budget", int'(err), 0);

      // budget exhausted aborts the session
      open_session();
      send_byte(9, 8'hFF, 8'h77, 2, 1'b0, ended);
      send_byte(10, 8'hFF, 8'h81, MAXP + 1, 1'b0, ended);  // R7
      chk(ended && mem[10] == 8'hFF, "R7 aborted cell", int'(mem[10]), 255);
      repeat (5) @(negedge clk);
      chk(err && int'(err_addr) == 10 && !busy, "R7 sticky err", int'(err), 1);

      // start clears the error, then random traffic
      open_session();
      chk(!err, "R10 err cleared by start", int'(err), 0);
      for (int k = 0; k < 30; k++) begin
         logic [DW-1:0] o, t;
         int n;
         o = ($urandom_range(0, 3) == 0) ? DW'($urandom) : 8'hFF;
         t = ($urandom_range(0, 5) == 0) ? DW'($urandom) : (o & DW'($urandom));
         n = $urandom_range(1, MAXP);
         send_byte(20 + k, o, t, n, k == 29, ended);
         if (ended) break;
      end

      if (!wd_hit) begin
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule